// File: doc/BRIEF.md
# Byte FIFO DMA Request Generator

This block connects a byte-wide serial bus master to a DMA controller. The master's transmit and receive paths each have an 8-entry byte FIFO. The bit-level engine is not part of the block. It appears only as push strobes (received bytes into the receive FIFO), pop strobes (outgoing bytes out of the transmit FIFO) and a byte-completed strobe. The DMA side fills the transmit FIFO and drains the receive FIFO through the same kind of strobes.

From the two fill levels, two programmable trigger thresholds and a counter of bytes still to be moved, the block drives two registered request lines to the DMA controller:

- a single-transfer request, raised when one byte can be moved;
- a burst request, raised when enough data is waiting, or when the transfer is near its end and the transmit FIFO has room.

The DMA controller returns a done pulse for each direction. Each pulse becomes an interrupt status bit that can be masked and cleared by writing a one. A trigger crossing in either FIFO sets a service interrupt bit in the same way.

Top module: `dma_req_gen`

## Requirements
- R1: Each FIFO holds up to DEPTH (8) bytes and returns them in push order. `*_data_o` shows the oldest entry. A push to a full FIFO is ignored and sets a sticky overflow flag. A pop from an empty FIFO is ignored and sets a sticky underflow flag. When a FIFO is full and push and pop arrive together, the pop is taken and the push is refused.
- R2: Both request outputs stay low unless `burst_en_i` and `dma_chan_en_i` were both high in the previous cycle.
- R3: When enabled, `sreq_o` is high when the receive level is at least 1 or the transmit level is below DEPTH.
- R4: When enabled, `breq_o` is high when the receive level is strictly greater than `rx_trig_i`.
- R5: When enabled, `breq_o` is also high when `burst_left_o` is less than 4 and the transmit level is strictly below `tx_trig_i`.
- R6: `burst_load_i` loads `burst_len_i` into `burst_left_o`. Load takes priority over `byte_done_i`. Each `byte_done_i` lowers `burst_left_o` by one, and the count stops at zero.
- R7: In `int_raw_o`, bit 0 is the transmit DMA done bit and bit 1 is the receive DMA done bit. A done pulse sets its bit in the next cycle. A one in the matching bit of `int_clr_i` clears it. A set and a clear in the same cycle leave the bit set. `int_o` equals `int_raw_o & int_mask_i`.
- R8: Bit 2 of `int_raw_o` is set one cycle after the transmit condition (level < `tx_trig_i`) goes from false to true. Bit 3 is set one cycle after the receive condition (level > `rx_trig_i`) goes from false to true. A condition that stays true does not set its bit again after a clear.
- R9: A flush empties its FIFO in the next cycle and clears that FIFO's overflow and underflow flags. A flush takes priority over a push or pop in the same cycle.
- R10: The request outputs are registered. They change in the cycle after the level change that causes them, both on assertion and on deassertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_en_i | input | 1 | Burst mode enabled in master control |
| dma_chan_en_i | input | 1 | DMA channel for the master enabled |
| tx_push_i | input | 1 | DMA writes a byte into the transmit FIFO |
| tx_data_i | input | 8 | Byte to write into the transmit FIFO |
| tx_pop_i | input | 1 | Engine takes a byte from the transmit FIFO |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_level_o | output | 4 | Transmit fill level |
| tx_flush_i | input | 1 | Empty the transmit FIFO |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| tx_udf_o | output | 1 | Sticky transmit underflow |
| rx_push_i | input | 1 | Engine writes a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | DMA reads a byte from the receive FIFO |
| rx_data_o | output | 8 | Oldest received byte |
| rx_level_o | output | 4 | Receive fill level |
| rx_flush_i | input | 1 | Empty the receive FIFO |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| rx_udf_o | output | 1 | Sticky receive underflow |
| tx_trig_i | input | 4 | Transmit trigger threshold |
| rx_trig_i | input | 4 | Receive trigger threshold |
| burst_load_i | input | 1 | Load the burst length |
| burst_len_i | input | 8 | Bytes in the coming transfer |
| byte_done_i | input | 1 | Engine completed one byte |
| burst_left_o | output | 8 | Bytes still to transfer |
| sreq_o | output | 1 | Single-transfer DMA request |
| breq_o | output | 1 | Burst DMA request |
| dma_tx_done_i | input | 1 | Transmit DMA done pulse |
| dma_rx_done_i | input | 1 | Receive DMA done pulse |
| int_mask_i | input | 4 | Interrupt mask, one bit per status bit |
| int_clr_i | input | 4 | Write-one-to-clear strobes |
| int_raw_o | output | 4 | Raw interrupt status |
| int_o | output | 4 | Masked interrupt status |

## Verification
A wrong fill level shows up as a wrong level output in the very next cycle. It reaches the request lines one cycle later, because the request decision depends on level against trigger. A sweep over every level and threshold therefore exposes an off-by-one compare within two cycles of the last strobe. A counter that fails to saturate, or a lost load priority, is visible at once on `burst_left_o`, and within one more cycle on `breq_o` whenever the transmit level is below its trigger. An interrupt edge detector that re-arms wrongly shows as a status bit that comes back one cycle after a clear.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int NIRQ    = 4;
  localparam int IRQ_DTX = 0;
  localparam int IRQ_DRX = 1;
  localparam int IRQ_STX = 2;
  localparam int IRQ_SRX = 3;
  typedef logic [NIRQ-1:0] irq_vec_t;
endpackage

// File: rtl/drq_fifo.sv
module drq_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LVW  = $clog2(DEPTH+1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           flush_i,
  input  logic           push_i,
  input  logic [DW-1:0]  data_i,
  input  logic           pop_i,
  output logic [DW-1:0]  data_o,
  output logic [LVW-1:0] level_o,
  output logic           ovf_o,
  output logic           udf_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic full, empty, do_push, do_pop;

  assign full    = (level_o == LVW'(DEPTH));
  assign empty   = (level_o == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && !full;
  assign data_o  = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0; rptr <= '0; level_o <= '0; ovf_o <= 1'b0; udf_o <= 1'b0;
    end else if (flush_i) begin
      wptr <= '0; rptr <= '0; level_o <= '0; ovf_o <= 1'b0; udf_o <= 1'b0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      level_o <= level_o + 1'b1;
      else if (do_pop && !do_push) level_o <= level_o - 1'b1;
      if (push_i && full)  ovf_o <= 1'b1;
      if (pop_i && empty)  udf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/drq_burst.sv
module drq_burst #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  input  logic          done_i,
  output logic [LW-1:0] left_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     left_o <= '0;
    else if (load_i)                 left_o <= len_i;
    else if (done_i && left_o != '0) left_o <= left_o - 1'b1;
  end
endmodule

// File: rtl/drq_req.sv
module drq_req #(
  parameter int DEPTH     = 8,
  parameter int LW        = 8,
  parameter int BURST_THR = 4,
  localparam int LVW      = $clog2(DEPTH+1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [LVW-1:0] tx_level_i,
  input  logic [LVW-1:0] rx_level_i,
  input  logic [LVW-1:0] tx_trig_i,
  input  logic [LVW-1:0] rx_trig_i,
  input  logic [LW-1:0]  left_i,
  output logic           sreq_o,
  output logic           breq_o
);
  logic s_d, b_d;
  always_comb begin
    s_d = en_i && ((rx_level_i != '0) || (tx_level_i != LVW'(DEPTH)));
    b_d = en_i && ((rx_level_i > rx_trig_i) ||
                   ((left_i < LW'(BURST_THR)) && (tx_level_i < tx_trig_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreq_o <= 1'b0; breq_o <= 1'b0;
    end else begin
      sreq_o <= s_d; breq_o <= b_d;
    end
  end
endmodule

// File: rtl/drq_irq.sv
module drq_irq
  import dma_req_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tx_done_i,
  input  logic     rx_done_i,
  input  logic     tx_svc_i,
  input  logic     rx_svc_i,
  input  irq_vec_t mask_i,
  input  irq_vec_t clr_i,
  output irq_vec_t raw_o,
  output irq_vec_t int_o
);
  logic tx_svc_q, rx_svc_q;
  irq_vec_t set;

  always_comb begin
    set          = '0;
    set[IRQ_DTX] = tx_done_i;
    set[IRQ_DRX] = rx_done_i;
    set[IRQ_STX] = tx_svc_i && !tx_svc_q;
    set[IRQ_SRX] = rx_svc_i && !rx_svc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o <= '0; tx_svc_q <= 1'b0; rx_svc_q <= 1'b0;
    end else begin
      raw_o    <= (raw_o & ~clr_i) | set;  // set wins over clear
      tx_svc_q <= tx_svc_i;
      rx_svc_q <= rx_svc_i;
    end
  end

  assign int_o = raw_o & mask_i;
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int DW        = 8,
  parameter int LW        = 8,
  parameter int BURST_THR = 4,
  localparam int LVW      = $clog2(DEPTH+1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            burst_en_i,
  input  logic            dma_chan_en_i,
  input  logic            tx_push_i,
  input  logic [DW-1:0]   tx_data_i,
  input  logic            tx_pop_i,
  output logic [DW-1:0]   tx_data_o,
  output logic [LVW-1:0]  tx_level_o,
  input  logic            tx_flush_i,
  output logic            tx_ovf_o,
  output logic            tx_udf_o,
  input  logic            rx_push_i,
  input  logic [DW-1:0]   rx_data_i,
  input  logic            rx_pop_i,
  output logic [DW-1:0]   rx_data_o,
  output logic [LVW-1:0]  rx_level_o,
  input  logic            rx_flush_i,
  output logic            rx_ovf_o,
  output logic            rx_udf_o,
  input  logic [LVW-1:0]  tx_trig_i,
  input  logic [LVW-1:0]  rx_trig_i,
  input  logic            burst_load_i,
  input  logic [LW-1:0]   burst_len_i,
  input  logic            byte_done_i,
  output logic [LW-1:0]   burst_left_o,
  output logic            sreq_o,
  output logic            breq_o,
  input  logic            dma_tx_done_i,
  input  logic            dma_rx_done_i,
  input  logic [NIRQ-1:0] int_mask_i,
  input  logic [NIRQ-1:0] int_clr_i,
  output logic [NIRQ-1:0] int_raw_o,
  output logic [NIRQ-1:0] int_o
);
  drq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_flush_i), .push_i(tx_push_i), .data_i(tx_data_i),
    .pop_i(tx_pop_i), .data_o(tx_data_o), .level_o(tx_level_o),
    .ovf_o(tx_ovf_o), .udf_o(tx_udf_o));

  drq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush_i), .push_i(rx_push_i), .data_i(rx_data_i),
    .pop_i(rx_pop_i), .data_o(rx_data_o), .level_o(rx_level_o),
    .ovf_o(rx_ovf_o), .udf_o(rx_udf_o));

  drq_burst #(.LW(LW)) u_burst (
    .clk_i, .rst_ni, .load_i(burst_load_i), .len_i(burst_len_i),
    .done_i(byte_done_i), .left_o(burst_left_o));

  drq_req #(.DEPTH(DEPTH), .LW(LW), .BURST_THR(BURST_THR)) u_req (
    .clk_i, .rst_ni, .en_i(burst_en_i && dma_chan_en_i),
    .tx_level_i(tx_level_o), .rx_level_i(rx_level_o),
    .tx_trig_i, .rx_trig_i, .left_i(burst_left_o),
    .sreq_o, .breq_o);

  drq_irq u_irq (
    .clk_i, .rst_ni, .tx_done_i(dma_tx_done_i), .rx_done_i(dma_rx_done_i),
    .tx_svc_i(tx_level_o < tx_trig_i), .rx_svc_i(rx_level_o > rx_trig_i),
    .mask_i(int_mask_i), .clr_i(int_clr_i), .raw_o(int_raw_o), .int_o(int_o));
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 8,
  localparam int LVW  = $clog2(DEPTH+1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           burst_en_i,
  input logic           dma_chan_en_i,
  input logic           sreq_o,
  input logic           breq_o,
  input logic           dma_tx_done_i,
  input logic           dma_rx_done_i,
  input logic [3:0]     int_raw_o,
  input logic           tx_flush_i,
  input logic           rx_flush_i,
  input logic [LVW-1:0] tx_level_o,
  input logic [LVW-1:0] rx_level_o,
  input logic           burst_load_i,
  input logic [LW-1:0]  burst_left_o
);
  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= LVW'(DEPTH)) && (rx_level_o <= LVW'(DEPTH)));

  assert_gated_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(burst_en_i && dma_chan_en_i) |=> !sreq_o && !breq_o);

  assert_no_count_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_load_i |=> burst_left_o <= $past(burst_left_o));

  assert_tx_done_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_tx_done_i |=> int_raw_o[0]);

  assert_rx_done_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_done_i |=> int_raw_o[1]);

  assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_i |=> tx_level_o == '0);

  assert_flush_empties_rx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i |=> rx_level_o == '0);
endmodule

bind dma_req_gen dma_req_gen_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/dma_req_gen_bench.sv
module dma_req_gen_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic burst_en = 0, chan_en = 0;
  logic tx_push = 0, tx_pop = 0, tx_flush = 0, rx_push = 0, rx_pop = 0, rx_flush = 0;
  logic [7:0] tx_data = 0, rx_data = 0, tx_q, rx_q;
  logic [3:0] tx_lvl, rx_lvl, tx_trig = 0, rx_trig = 8;
  logic tx_ovf, tx_udf, rx_ovf, rx_udf;
  logic burst_load = 0, byte_done = 0;
  logic [7:0] burst_len = 0, left;
  logic sreq, breq, dtx = 0, drx = 0;
  logic [3:0] mask = 0, clr = 0, raw, irq;

  int errors = 0, checks = 0;
  bit finished = 0;

  dma_req_gen u_dma_req_gen (
    .clk_i(clk), .rst_ni(rst_n), .burst_en_i(burst_en), .dma_chan_en_i(chan_en),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_pop_i(tx_pop), .tx_data_o(tx_q),
    .tx_level_o(tx_lvl), .tx_flush_i(tx_flush), .tx_ovf_o(tx_ovf), .tx_udf_o(tx_udf),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_pop_i(rx_pop), .rx_data_o(rx_q),
    .rx_level_o(rx_lvl), .rx_flush_i(rx_flush), .rx_ovf_o(rx_ovf), .rx_udf_o(rx_udf),
    .tx_trig_i(tx_trig), .rx_trig_i(rx_trig), .burst_load_i(burst_load),
    .burst_len_i(burst_len), .byte_done_i(byte_done), .burst_left_o(left),
    .sreq_o(sreq), .breq_o(breq), .dma_tx_done_i(dtx), .dma_rx_done_i(drx),
    .int_mask_i(mask), .int_clr_i(clr), .int_raw_o(raw), .int_o(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic tpush(logic [7:0] v);
    tx_push = 1; tx_data = v; cyc(); tx_push = 0;
  endtask
  task automatic rpush(logic [7:0] v);
    rx_push = 1; rx_data = v; cyc(); rx_push = 0;
  endtask
  task automatic tflush(); tx_flush = 1; cyc(); tx_flush = 0; endtask
  task automatic rflush(); rx_flush = 1; cyc(); rx_flush = 0; endtask
  task automatic load(int n);
    burst_len = 8'(n); burst_load = 1; cyc(); burst_load = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(2); rst_n = 1; cyc();
    // reset state
    chk("R1 reset tx level", tx_lvl, 0);
    chk("R1 reset rx level", rx_lvl, 0);
    chk("R2 reset sreq", sreq, 0);
    chk("R2 reset breq", breq, 0);
    chk("R7 reset raw", raw, 0);
    chk("R6 reset left", left, 0);

    // R1 order, overflow, underflow
    for (int i = 0; i < 9; i++) tpush(8'(8'h30 + i));
    chk("R1 full level", tx_lvl, 8);
    chk("R1 overflow flag", tx_ovf, 1);
    tx_push = 1; tx_data = 8'hEE; tx_pop = 1; cyc(); tx_push = 0; tx_pop = 0;
    chk("R1 full push+pop level", tx_lvl, 7);
    for (int i = 1; i < 8; i++) begin
      chk("R1 data order", tx_q, 8'h30 + i);
      tx_pop = 1; cyc(); tx_pop = 0;
    end
    chk("R1 empty level", tx_lvl, 0);
    chk("R1 no underflow yet", tx_udf, 0);
    tx_pop = 1; cyc(); tx_pop = 0;
    chk("R1 underflow flag", tx_udf, 1);
    chk("R1 level after bad pop", tx_lvl, 0);
    // R9 flush clears flags, beats push
    rpush(8'h11); rpush(8'h22);
    rx_flush = 1; rx_push = 1; cyc(); rx_flush = 0; rx_push = 0;
    chk("R9 rx flush level", rx_lvl, 0);
    tflush();
    chk("R9 flush clears ovf", tx_ovf, 0);
    chk("R9 flush clears udf", tx_udf, 0);

    // R6 burst counter
    load(3);
    chk("R6 load", left, 3);
    for (int i = 0; i < 5; i++) begin
      byte_done = 1; cyc(); byte_done = 0;
      chk("R6 decrement/saturate", left, (3 - (i + 1)) < 0 ? 0 : 3 - (i + 1));
    end
    burst_len = 6; burst_load = 1; byte_done = 1; cyc(); burst_load = 0; byte_done = 0;
    chk("R6 load priority", left, 6);

    // R2 enables
    rpush(1); rpush(2); rx_trig = 0; cyc(2);
    chk("R2 disabled sreq", sreq, 0);
    chk("R2 disabled breq", breq, 0);
    burst_en = 1; cyc(2);
    chk("R2 chan off sreq", sreq, 0);
    burst_en = 0; chan_en = 1; cyc(2);
    chk("R2 burst off breq", breq, 0);
    burst_en = 1; cyc(2);
    chk("R2 enabled sreq", sreq, 1);
    chk("R2 enabled breq", breq, 1);
    rflush();

    // R5 / R3 tx sweep: rx empty, rx_trig=8 so rx term is false
    rx_trig = 8;
    for (int r = 0; r < 6; r++) begin
      load(r);
      for (int t = 0; t < 9; t++) begin
        for (int l = 0; l < 9; l++) begin
          tflush(); tx_trig = 4'(t);
          for (int k = 0; k < l; k++) tpush(8'(k));
          cyc();
          chk("R5 tx burst request", breq, (r < 4 && l < t) ? 1 : 0);
          chk("R3 tx single request", sreq, (l != 8) ? 1 : 0);
        end
      end
    end

    // R4 / R3 rx sweep: tx full and remaining large
    load(8); tflush(); tx_trig = 0;
    for (int k = 0; k < 8; k++) tpush(8'(k));
    for (int t = 0; t < 9; t++) begin
      for (int l = 0; l < 9; l++) begin
        rflush(); rx_trig = 4'(t);
        for (int k = 0; k < l; k++) rpush(8'(k));
        cyc();
        chk("R4 rx burst request", breq, (l > t) ? 1 : 0);
        chk("R3 rx single request", sreq, (l > 0) ? 1 : 0);
      end
    end

    // R10 registered timing: tx full, rx empty
    rflush(); rx_trig = 8; cyc();
    chk("R10 idle sreq", sreq, 0);
    rpush(8'h5A);
    chk("R10 sreq not yet", sreq, 0);
    cyc();
    chk("R10 sreq asserted", sreq, 1);
    chk("R1 rx data", rx_q, 8'h5A);
    rx_pop = 1; cyc(); rx_pop = 0;
    chk("R10 sreq still high", sreq, 1);
    cyc();
    chk("R10 sreq deasserted", sreq, 0);

    // R7 DMA done interrupts
    clr = 4'hF; cyc(); clr = 0; mask = 0;
    dtx = 1; cyc(); dtx = 0;
    chk("R7 tx done raw", raw[0], 1);
    chk("R7 masked off", irq[0], 0);
    mask = 4'b0001; #1;
    chk("R7 masked on", irq[0], 1);
    clr = 4'b0001; cyc(); clr = 0;
    chk("R7 w1c", raw[0], 0);
    drx = 1; clr = 4'b0010; cyc(); drx = 0; clr = 0;
    chk("R7 set beats clear", raw[1], 1);
    chk("R7 rx masked off", irq[1], 0);
    clr = 4'b0010; cyc(); clr = 0;
    chk("R7 rx w1c", raw[1], 0);

    // R8 service edges
    tflush(); tx_trig = 0; rflush(); rx_trig = 8; cyc();
    clr = 4'hF; cyc(); clr = 0;
    tx_trig = 3; cyc();
    chk("R8 tx service set", raw[2], 1);
    clr = 4'b0100; cyc(); clr = 0; cyc(2);
    chk("R8 no re-set while true", raw[2], 0);
    for (int k = 0; k < 3; k++) tpush(8'(k));
    cyc();
    chk("R8 no set when false", raw[2], 0);
    tx_pop = 1; cyc(); tx_pop = 0; cyc();
    chk("R8 tx service re-crossed", raw[2], 1);
    rx_trig = 1; rpush(1);
    cyc();
    chk("R8 rx not crossed", raw[3], 0);
    rpush(2); cyc();
    chk("R8 rx service set", raw[3], 1);
    mask = 4'b1000; #1;
    chk("R8 rx masked out", irq[3], 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule